// File: doc/BRIEF.md
# Post-Update Load/Store Unit

This block executes fixed-point loads and stores that use post-update addressing on a 64-bit datapath. Memory is accessed at the base register's value as it was before the instruction. The base register is then written with the sum of the base and an offset. The offset is either a sign-extended immediate or the value of an index register. A conventional update form accesses memory at the summed address instead; here the sum is used only for the write-back.

The unit takes one decoded operation at a time. An operation carries:
- the access size,
- load or store,
- sign or zero extension,
- immediate or indexed offset,
- the base, index, immediate and store-data values,
- the target and base register numbers.

The unit issues a single request on a simple memory port with a valid/ready handshake. It waits for the response. It then reports completion together with one write-back (for a store) or two write-backs on separate ports (for a load). Operations whose register numbers or field combination form an invalid form are refused with a one-cycle illegal flag.

Top module: `pu_lsu`

## Requirements
- R1: The memory request address is the old base value with its three low bits cleared. The byte offset inside the 8-byte word is the old base's low three bits. `mem_req_be` bit k selects the byte at offset k, and that byte travels on `mem_req_wdata[63-8k -: 8]` / `mem_rsp_rdata[63-8k -: 8]` (big-endian lanes).
- R2: In immediate form, the base write-back value is old base plus the 16-bit immediate sign-extended. In indexed form (`op_indexed`=1), it is old base plus `index_val`.
- R3: For an 8-byte access in immediate form, the offset is immediate bits 15..2 followed by two zero bits, sign-extended. Immediate bits 1..0 are ignored.
- R4: `op_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. A load with `op_signed`=0 returns the accessed bytes, first byte most significant, in the low bits of the target write-back, with every higher bit cleared.
- R5: A load with `op_signed`=1 sign-extends the accessed value. This is legal for 2-byte loads in both forms and for 4-byte loads in indexed form only.
- R6: A store writes the low 1, 2, 4 or 8 bytes of `store_val`, most significant of them at the lowest address. Byte enables are set for exactly the accessed lanes, and unselected data lanes are zero. A store makes no target write-back, and `op_signed` has no effect on it.
- R7: A load whose base register number is 0, or equals its target register number, is invalid. `illegal` is high for one cycle, and there is no memory request, no write-back and no `done`.
- R8: A store whose base register number is 0 is invalid in the same way. A store whose base number equals its source number is legal.
- R9: These are also invalid in the same way: a sign-extending 1-byte or 8-byte load, a sign-extending 4-byte load in immediate form, and any access whose byte offset is not a multiple of its size.
- R10: The request stays asserted with stable address, enables and data until `mem_req_ready`. In the cycle after the response valid, `done` is high for exactly one cycle. In that same cycle the base write-back and, for a load, the target write-back are presented.
- R11: `op_ready` is high only when the unit is idle. An operation is accepted when `op_valid` and `op_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_size | input | 2 | Access size code |
| op_store | input | 1 | 1 = store, 0 = load |
| op_signed | input | 1 | Sign-extend loaded value |
| op_indexed | input | 1 | Offset from index value instead of immediate |
| base_val | input | 64 | Old base register value |
| index_val | input | 64 | Index register value |
| imm_val | input | 16 | Immediate offset field |
| store_val | input | 64 | Store source register value |
| rt_num | input | 5 | Target (load) or source (store) register number |
| ra_num | input | 5 | Base register number |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | 8-byte-aligned request address |
| mem_req_we | output | 1 | Request is a write |
| mem_req_be | output | 8 | Byte-lane enables |
| mem_req_wdata | output | 64 | Lane-placed store data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 64 | Response data word |
| done | output | 1 | Operation completed (one cycle) |
| illegal | output | 1 | Operation refused as invalid (one cycle) |
| wb_t_en | output | 1 | Target write-back enable |
| wb_t_reg | output | 5 | Target write-back register number |
| wb_t_data | output | 64 | Target write-back value |
| wb_a_en | output | 1 | Base write-back enable |
| wb_a_reg | output | 5 | Base write-back register number |
| wb_a_data | output | 64 | Updated base value |

## Verification
The bench uses base values with non-zero byte offsets. A unit that accessed memory at the summed address, or that ignored the offset inside the word, then shows a wrong request address, wrong enables or wrong lanes. Loads of bytes with and without the top bit set separate zero extension from sign extension, so a missing or misplaced extension shows up in the target value. 8-byte immediate accesses use immediates whose two low bits are set: an update that did not drop them lands off by up to three. Each invalid combination (base zero, base equal to target, unsupported signed forms, misalignment) is offered alone. A unit that let any of them through would raise a request or a write-back instead of the illegal pulse.

// File: rtl/pu_lsu_pkg.sv
package pu_lsu_pkg;

  localparam int XLEN  = 64;
  localparam int LANES = XLEN / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int IMM_W = 16;
  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } lsu_state_e;

  typedef struct packed {
    acc_size_e        size;
    logic             store;
    logic             sgn;
    logic             indexed;
    logic [XLEN-1:0]  base;
    logic [XLEN-1:0]  index;
    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  sdata;
    logic [REG_W-1:0] rt;
    logic [REG_W-1:0] ra;
  } lsu_op_t;

  // number of bytes touched by an access size
  function automatic int size_bytes(acc_size_e s);
    return 1 << int'(s);
  endfunction

  // offset added to the base for the write-back
  function automatic logic [XLEN-1:0] step_amount(lsu_op_t op);
    logic [XLEN-1:0] r;
    if (op.indexed)
      r = op.index;
    else if (op.size == SZ_DWORD)
      r = {{(XLEN-IMM_W){op.imm[IMM_W-1]}}, op.imm[IMM_W-1:2], 2'b00};
    else
      r = {{(XLEN-IMM_W){op.imm[IMM_W-1]}}, op.imm};
    return r;
  endfunction

  // the byte offset is not a multiple of the access size
  function automatic logic misaligned(acc_size_e s, logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] lowmask;
    lowmask = OFF_W'(size_bytes(s) - 1);
    return (off & lowmask) != '0;
  endfunction

  // bit distance between the word's LSB and the access's LSB (big-endian lanes)
  function automatic int lane_shift(acc_size_e s, logic [OFF_W-1:0] off);
    return XLEN - 8 * (int'(off) + size_bytes(s));
  endfunction

  // mask of the low bits covered by an access size
  function automatic logic [XLEN-1:0] low_mask(acc_size_e s);
    return {XLEN{1'b1}} >> (XLEN - 8 * size_bytes(s));
  endfunction

  // zero or sign extension of a right-justified loaded value
  function automatic logic [XLEN-1:0] extend_load(acc_size_e s, logic sgn,
                                                  logic [XLEN-1:0] raw);
    logic [XLEN-1:0] r;
    case (s)
      SZ_BYTE: r = {{(XLEN-8){1'b0}}, raw[7:0]};
      SZ_HALF: r = {{(XLEN-16){sgn & raw[15]}}, raw[15:0]};
      SZ_WORD: r = {{(XLEN-32){sgn & raw[31]}}, raw[31:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pu_lsu_legal.sv
module pu_lsu_legal
  import pu_lsu_pkg::*;
(
  input  lsu_op_t op,
  output logic    bad_regs,
  output logic    bad_form,
  output logic    bad_align,
  output logic    form_bad
);

  logic base_is_zero;
  logic base_is_target;
  logic sign_unsupported;

  assign base_is_zero   = (op.ra == '0);
  assign base_is_target = (op.ra == op.rt);

  // only halfword (both forms) and indexed word may sign-extend
  always_comb begin
    sign_unsupported = 1'b0;
    if (!op.store && op.sgn) begin
      case (op.size)
        SZ_BYTE:  sign_unsupported = 1'b1;
        SZ_DWORD: sign_unsupported = 1'b1;
        SZ_WORD:  sign_unsupported = !op.indexed;
        default:  sign_unsupported = 1'b0;
      endcase
    end
  end

  assign bad_regs  = base_is_zero || (!op.store && base_is_target);
  assign bad_form  = sign_unsupported;
  assign bad_align = misaligned(op.size, op.base[OFF_W-1:0]);
  assign form_bad  = bad_regs || bad_form || bad_align;

endmodule

// File: rtl/pu_lsu_lanes.sv
module pu_lsu_lanes
  import pu_lsu_pkg::*;
(
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  input  logic [XLEN-1:0]  sdata,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0]  wdata
);

  int nbytes;
  int first_lane;
  logic [XLEN-1:0] trimmed;

  always_comb begin
    nbytes     = size_bytes(size);
    first_lane = int'(off);
  end

  // one enable per byte lane: lane k is inside [off, off+n)
  for (genvar k = 0; k < LANES; k++) begin : g_be
    assign be[k] = (k >= first_lane) && (k < first_lane + nbytes);
  end

  assign trimmed = sdata & low_mask(size);
  assign wdata   = trimmed << lane_shift(size, off);

endmodule

// File: rtl/pu_lsu_extract.sv
module pu_lsu_extract
  import pu_lsu_pkg::*;
(
  input  acc_size_e        size,
  input  logic             sgn,
  input  logic [OFF_W-1:0] off,
  input  logic [XLEN-1:0]  rdata,
  output logic [XLEN-1:0]  value
);

  logic [XLEN-1:0] justified;

  assign justified = rdata >> lane_shift(size, off);
  assign value     = extend_load(size, sgn, justified);

endmodule

// File: rtl/pu_lsu.sv
module pu_lsu
  import pu_lsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [1:0]       op_size,
  input  logic             op_store,
  input  logic             op_signed,
  input  logic             op_indexed,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  index_val,
  input  logic [IMM_W-1:0] imm_val,
  input  logic [XLEN-1:0]  store_val,
  input  logic [REG_W-1:0] rt_num,
  input  logic [REG_W-1:0] ra_num,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [XLEN-1:0]  mem_req_addr,
  output logic             mem_req_we,
  output logic [LANES-1:0] mem_req_be,
  output logic [XLEN-1:0]  mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [XLEN-1:0]  mem_rsp_rdata,
  output logic             done,
  output logic             illegal,
  output logic             wb_t_en,
  output logic [REG_W-1:0] wb_t_reg,
  output logic [XLEN-1:0]  wb_t_data,
  output logic             wb_a_en,
  output logic [REG_W-1:0] wb_a_reg,
  output logic [XLEN-1:0]  wb_a_data
);

  lsu_state_e state_q;
  lsu_op_t    op_in;
  lsu_op_t    op_q;

  // named events for the checker
  logic op_fire;
  logic accept_good;
  logic accept_bad;
  logic req_fire;
  logic rsp_fire;

  logic bad_regs, bad_form, bad_align, form_bad;
  logic [OFF_W-1:0] byte_off;
  logic [XLEN-1:0]  next_base;
  logic [XLEN-1:0]  load_value;

  logic             done_q, illegal_q;
  logic             wb_t_en_q, wb_a_en_q;
  logic [REG_W-1:0] wb_t_reg_q, wb_a_reg_q;
  logic [XLEN-1:0]  wb_t_data_q, wb_a_data_q;

  always_comb begin
    op_in.size    = acc_size_e'(op_size);
    op_in.store   = op_store;
    op_in.sgn     = op_signed;
    op_in.indexed = op_indexed;
    op_in.base    = base_val;
    op_in.index   = index_val;
    op_in.imm     = imm_val;
    op_in.sdata   = store_val;
    op_in.rt      = rt_num;
    op_in.ra      = ra_num;
  end

  pu_lsu_legal u_legal (
    .op        (op_in),
    .bad_regs  (bad_regs),
    .bad_form  (bad_form),
    .bad_align (bad_align),
    .form_bad  (form_bad)
  );

  assign op_ready    = (state_q == ST_IDLE);
  assign op_fire     = op_valid && op_ready;
  assign accept_good = op_fire && !form_bad;
  assign accept_bad  = op_fire && form_bad;

  assign mem_req_valid = (state_q == ST_REQ);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_fire      = (state_q == ST_RSP) && mem_rsp_valid;

  // access at the unmodified base, summed value only for write-back
  assign byte_off     = op_q.base[OFF_W-1:0];
  assign mem_req_addr = {op_q.base[XLEN-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_we   = op_q.store;
  assign next_base    = op_q.base + step_amount(op_q);

  pu_lsu_lanes u_lanes (
    .size  (op_q.size),
    .off   (byte_off),
    .sdata (op_q.sdata),
    .be    (mem_req_be),
    .wdata (mem_req_wdata)
  );

  pu_lsu_extract u_extract (
    .size  (op_q.size),
    .sgn   (op_q.sgn),
    .off   (byte_off),
    .rdata (mem_rsp_rdata),
    .value (load_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_good) begin
          state_q <= ST_REQ;
          op_q    <= op_in;
        end
        ST_REQ:  if (req_fire) state_q <= ST_RSP;
        ST_RSP:  if (rsp_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q      <= 1'b0;
      illegal_q   <= 1'b0;
      wb_t_en_q   <= 1'b0;
      wb_a_en_q   <= 1'b0;
      wb_t_reg_q  <= '0;
      wb_a_reg_q  <= '0;
      wb_t_data_q <= '0;
      wb_a_data_q <= '0;
    end else begin
      done_q    <= rsp_fire;
      illegal_q <= accept_bad;
      wb_t_en_q <= rsp_fire && !op_q.store;
      wb_a_en_q <= rsp_fire;
      if (rsp_fire) begin
        wb_t_reg_q  <= op_q.rt;
        wb_a_reg_q  <= op_q.ra;
        wb_t_data_q <= op_q.store ? '0 : load_value;
        wb_a_data_q <= next_base;
      end
    end
  end

  assign done      = done_q;
  assign illegal   = illegal_q;
  assign wb_t_en   = wb_t_en_q;
  assign wb_t_reg  = wb_t_reg_q;
  assign wb_t_data = wb_t_data_q;
  assign wb_a_en   = wb_a_en_q;
  assign wb_a_reg  = wb_a_reg_q;
  assign wb_a_data = wb_a_data_q;

endmodule

// File: rtl/pu_lsu_chk.sv
module pu_lsu_chk
  import pu_lsu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [XLEN-1:0]  mem_req_addr,
  input logic [LANES-1:0] mem_req_be,
  input logic [XLEN-1:0]  mem_req_wdata,
  input logic             illegal,
  input logic             done,
  input logic             wb_t_en,
  input logic             wb_a_en,
  input logic [REG_W-1:0] wb_a_reg,
  input logic             rsp_fire,
  input logic             accept_bad
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_be) && $stable(mem_req_wdata));

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFF_W-1:0] == '0);

  p_be_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_be) == 1 || $countones(mem_req_be) == 2 ||
                       $countones(mem_req_be) == 4 || $countones(mem_req_be) == 8));

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req_valid && !done && !wb_a_en && !wb_t_en);

  p_bad_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> illegal);

  p_done_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire |=> done && wb_a_en);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_target_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_t_en |-> done);

  p_no_zero_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_a_en |-> wb_a_reg != '0);

endmodule

bind pu_lsu pu_lsu_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_req_be    (mem_req_be),
  .mem_req_wdata (mem_req_wdata),
  .illegal       (illegal),
  .done          (done),
  .wb_t_en       (wb_t_en),
  .wb_a_en       (wb_a_en),
  .wb_a_reg      (wb_a_reg),
  .rsp_fire      (rsp_fire),
  .accept_bad    (accept_bad)
);

// File: tb/pu_lsu_test.sv
`timescale 1ns/1ps
module pu_lsu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_store = 1'b0;
  logic        op_signed = 1'b0;
  logic        op_indexed = 1'b0;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [15:0] imm_val = '0;
  logic [63:0] store_val = '0;
  logic [4:0]  rt_num = '0;
  logic [4:0]  ra_num = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_req_we;
  logic [7:0]  mem_req_be;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata;
  logic        done, illegal;
  logic        wb_t_en, wb_a_en;
  logic [4:0]  wb_t_reg, wb_a_reg;
  logic [63:0] wb_t_data, wb_a_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_img [8];

  always #2.5 clk = ~clk;

  // memory word image, byte k on lane k counted from the top
  always_comb begin
    mem_rsp_rdata = '0;
    for (int k = 0; k < 8; k++) mem_rsp_rdata[63-8*k -: 8] = mem_img[k];
  end

  pu_lsu uut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive_op(input logic [1:0] sz, input logic st, input logic sg,
                          input logic ix, input logic [63:0] base,
                          input logic [63:0] idx, input logic [15:0] imm,
                          input logic [63:0] sd, input logic [4:0] rt,
                          input logic [4:0] ra);
    @(negedge clk);
    op_size = sz; op_store = st; op_signed = sg; op_indexed = ix;
    base_val = base; index_val = idx; imm_val = imm; store_val = sd;
    rt_num = rt; ra_num = ra; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // legal operation through the full handshake
  task automatic run_op(input string rq, input logic [1:0] sz, input logic st,
                        input logic sg, input logic ix, input logic [63:0] base,
                        input logic [63:0] idx, input logic [15:0] imm,
                        input logic [63:0] sd, input logic [4:0] rt,
                        input logic [4:0] ra, input int lat);
    int n, off;
    logic [7:0]  e_be;
    logic [63:0] e_wd, e_ld, e_base, e_addr;
    n = 1 << sz;
    off = int'(base[2:0]);
    e_addr = {base[63:3], 3'b000};
    e_be = '0;
    for (int k = 0; k < 8; k++) if (k >= off && k < off + n) e_be[k] = 1'b1;
    e_wd = '0;
    for (int j = 0; j < n; j++) e_wd[63-8*(off+j) -: 8] = sd[8*(n-1-j) +: 8];
    e_ld = '0;
    for (int j = 0; j < n; j++) e_ld = (e_ld << 8) | 64'(mem_img[off+j]);
    if (sg && n < 8 && e_ld[8*n-1]) e_ld = e_ld | (~64'd0 << (8*n));
    if (ix) e_base = base + idx;
    else if (sz == 2'd3) e_base = base + {{48{imm[15]}}, imm[15:2], 2'b00};
    else e_base = base + {{48{imm[15]}}, imm};

    drive_op(sz, st, sg, ix, base, idx, imm, sd, rt, ra);
    chk(mem_req_valid == 1'b1, "R1", "request raised", 64'(mem_req_valid), 64'd1);
    chk(op_ready == 1'b0, "R11", "busy not ready", 64'(op_ready), 64'd0);
    chk(mem_req_addr == e_addr, "R1", "request address", mem_req_addr, e_addr);
    chk(mem_req_be == e_be, "R1", "byte enables", 64'(mem_req_be), 64'(e_be));
    chk(mem_req_we == st, "R6", "write flag", 64'(mem_req_we), 64'(st));
    if (st) chk(mem_req_wdata == e_wd, "R6", "store lanes", mem_req_wdata, e_wd);
    repeat (lat) @(negedge clk);
    if (lat > 0)
      chk(mem_req_valid && mem_req_addr == e_addr && mem_req_be == e_be, "R10",
          "request held", mem_req_addr, e_addr);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid == 1'b0 && done == 1'b0, "R10", "waiting response",
        64'(done), 64'd0);
    mem_rsp_valid = 1'b1;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(done == 1'b1, "R10", "done pulse", 64'(done), 64'd1);
    chk(wb_a_en == 1'b1 && wb_a_reg == ra, "R10", "base write-back reg",
        64'(wb_a_reg), 64'(ra));
    chk(wb_a_data == e_base, sz == 2'd3 && !ix ? "R3" : "R2", "updated base",
        wb_a_data, e_base);
    chk(wb_t_en == !st, st ? "R6" : "R10", "target enable", 64'(wb_t_en), 64'(!st));
    if (!st) begin
      chk(wb_t_reg == rt, "R10", "target reg", 64'(wb_t_reg), 64'(rt));
      chk(wb_t_data == e_ld, sg ? "R5" : "R4", "loaded value", wb_t_data, e_ld);
    end
    @(negedge clk);
    chk(done == 1'b0 && wb_a_en == 1'b0 && wb_t_en == 1'b0, "R10", "single done",
        64'(done), 64'd0);
    chk(op_ready == 1'b1, "R11", "idle again", 64'(op_ready), 64'd1);
  endtask

  // invalid operation: one illegal pulse, nothing else
  task automatic run_bad(input string rq, input logic [1:0] sz, input logic st,
                         input logic sg, input logic ix, input logic [63:0] base,
                         input logic [4:0] rt, input logic [4:0] ra);
    drive_op(sz, st, sg, ix, base, 64'h40, 16'h0010, 64'h1122334455667788, rt, ra);
    chk(illegal == 1'b1, rq, "illegal pulse", 64'(illegal), 64'd1);
    chk(mem_req_valid == 1'b0 && wb_a_en == 1'b0 && wb_t_en == 1'b0 && done == 1'b0,
        rq, "no access or write-back", 64'(mem_req_valid), 64'd0);
    chk(op_ready == 1'b1, rq, "still idle", 64'(op_ready), 64'd1);
    @(negedge clk);
    chk(illegal == 1'b0 && mem_req_valid == 1'b0 && done == 1'b0, rq,
        "quiet after pulse", 64'(illegal), 64'd0);
  endtask

  task automatic test_reset();
    chk(op_ready == 1'b1 && mem_req_valid == 1'b0, "R11", "reset idle",
        64'(mem_req_valid), 64'd0);
    chk(done == 1'b0 && illegal == 1'b0 && wb_a_en == 1'b0 && wb_t_en == 1'b0,
        "R10", "reset outputs quiet", 64'(done), 64'd0);
  endtask

  task automatic test_loads();
    // R4 zero-extend byte, positive immediate, offset 3
    run_op("R4", 2'd0, 0, 0, 0, 64'h0000_1000_0000_2003, 0, 16'h0020, 0, 5'd3, 5'd4, 0);
    // R4 zero-extend halfword of a negative-looking value, negative immediate
    run_op("R4", 2'd1, 0, 0, 0, 64'h2002, 0, 16'hFFF0, 0, 5'd6, 5'd7, 1);
    // R5 sign-extend halfword negative and positive
    run_op("R5", 2'd1, 0, 1, 0, 64'h2002, 0, 16'h0004, 0, 5'd8, 5'd9, 0);
    run_op("R5", 2'd1, 0, 1, 1, 64'h2000, 64'h18, 0, 0, 5'd8, 5'd9, 0);
    // R4 zero-extend word indexed; R5 sign-extend word indexed
    run_op("R4", 2'd2, 0, 0, 1, 64'h3004, 64'hFFFF_FFFF_FFFF_FFF8, 0, 0, 5'd10, 5'd11, 2);
    run_op("R5", 2'd2, 0, 1, 1, 64'h3004, 64'h100, 0, 0, 5'd10, 5'd11, 0);
    run_op("R5", 2'd2, 0, 1, 1, 64'h3000, 64'h100, 0, 0, 5'd12, 5'd11, 0);
    // R3 doubleword immediate: low immediate bits ignored, negative offset
    run_op("R3", 2'd3, 0, 0, 0, 64'h4000, 0, 16'hFFEB, 0, 5'd13, 5'd14, 3);
    run_op("R3", 2'd3, 0, 0, 0, 64'h4000, 0, 16'h0013, 0, 5'd13, 5'd14, 0);
    // doubleword indexed
    run_op("R2", 2'd3, 0, 0, 1, 64'h4008, 64'h28, 0, 0, 5'd15, 5'd16, 0);
  endtask

  task automatic test_stores();
    // R6 store byte, op_signed set has no effect
    run_op("R6", 2'd0, 1, 1, 0, 64'h5005, 0, 16'h0001, 64'hDEAD_BEEF_CAFE_F00D, 5'd1, 5'd2, 0);
    run_op("R6", 2'd1, 1, 0, 1, 64'h5006, 64'h10, 0, 64'h0123_4567_89AB_CDEF, 5'd1, 5'd2, 1);
    run_op("R6", 2'd2, 1, 0, 0, 64'h5004, 0, 16'h8000, 64'hAAAA_BBBB_1357_9BDF, 5'd3, 5'd2, 0);
    // R3 store doubleword immediate
    run_op("R3", 2'd3, 1, 0, 0, 64'h6000, 0, 16'h0027, 64'h0102_0304_0506_0708, 5'd3, 5'd2, 0);
    // R8 store with base equal to source is legal
    run_op("R8", 2'd2, 1, 0, 1, 64'h6000, 64'h4, 0, 64'h55, 5'd9, 5'd9, 0);
  endtask

  task automatic test_invalid();
    run_bad("R7", 2'd0, 0, 0, 0, 64'h100, 5'd3, 5'd0);
    run_bad("R7", 2'd2, 0, 0, 1, 64'h100, 5'd6, 5'd6);
    run_bad("R8", 2'd1, 1, 0, 0, 64'h100, 5'd3, 5'd0);
    run_bad("R9", 2'd0, 0, 1, 0, 64'h100, 5'd3, 5'd4);
    run_bad("R9", 2'd3, 0, 1, 1, 64'h100, 5'd3, 5'd4);
    run_bad("R9", 2'd2, 0, 1, 0, 64'h100, 5'd3, 5'd4);
    run_bad("R9", 2'd1, 0, 0, 0, 64'h101, 5'd3, 5'd4);
    run_bad("R9", 2'd3, 1, 0, 1, 64'h104, 5'd3, 5'd4);
  endtask

  initial begin
    mem_img[0] = 8'h12; mem_img[1] = 8'h34; mem_img[2] = 8'h96; mem_img[3] = 8'h78;
    mem_img[4] = 8'hC4; mem_img[5] = 8'hD5; mem_img[6] = 8'hE6; mem_img[7] = 8'hF7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_loads();
    test_stores();
    test_invalid();
    run_op("R10", 2'd1, 0, 0, 0, 64'h7000, 0, 16'h0002, 0, 5'd20, 5'd21, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule